// File: doc/BRIEF.md
# Thirty-Two-Line GPIO Controller with Grouped Interrupts

This block is a general-purpose I/O controller with 32 lines behind a simple single-cycle register bus. Every line can be set to drive a value onto its pad or to sample it. Output lines can be gated by a slow square wave so that an LED can blink without software. Input lines pass through a two-flop synchronizer. A per-line polarity bit then decides which level counts as active. The corrected value is what software reads back, and it is also what both interrupt paths use.

Each line has two interrupt sources. The level source is the corrected input gated by a level-enable bit and is not held. The edge source latches a rising transition of the corrected input into a pending register, and software acknowledges it by writing zeros. Pending sources are merged in groups of eight lines, so there is one interrupt output for each byte of the line vector. Falling-edge or active-low behaviour comes from setting the polarity bit of the line.

Top module: `gpio_ctrl`

## Requirements
- R1: After synchronous reset the edge-pending, edge-enable and level-enable registers read 0. The direction register reads all ones, so every line is an input. Output, blink and polarity registers read 0. All interrupt outputs are low and no pad output enable is asserted.
- R2: Register map by byte address. 0x00 is output value, 0x04 is direction, 0x08 is blink enable, 0x0C is polarity, 0x10 is corrected input (read-only), 0x14 is edge pending, 0x18 is edge enable and 0x1C is level enable. A direction bit of 0 makes the line an output: its pad enable is high and its pad value is the output bit, unless blink gating applies. A direction bit of 1 leaves the pad enable low.
- R3: The register at 0x10 returns the pad level XOR the polarity bit. A pad change shows there after exactly two clock edges, not after one. Writes to 0x10 have no effect.
- R4: A line's level source is its corrected input ANDed with its level-enable bit. It is not latched: it follows the input two edges after each pad change. With polarity 1, a low pad is active.
- R5: A 0-to-1 change of a corrected input bit sets its edge-pending bit on the third clock edge after the pad change. The bit stays set after the input returns. A 1-to-0 change sets nothing, so with polarity 1 only falling pad edges latch.
- R6: An edge-pending bit reaches the interrupt output only when its edge-enable bit is 1. The pending bit latches whether or not the enable bit is set.
- R7: A write to 0x14 clears every pending bit whose data bit is 0 and keeps every bit whose data bit is 1. Writing 0 clears all of them.
- R8: When a new rising edge and a clearing write reach the same pending bit on the same clock edge, the bit ends up set.
- R9: Interrupt output g is the OR of the level and enabled edge sources of lines 8g to 8g+7. A line never affects another group's output.
- R10: When a line's direction is output and its blink bit is 1, the pad value is its output bit ANDed with a square wave of period 2^BLINK_W clocks, high for half the period. With the blink bit 0 the output bit drives the pad unchanged.
- R11: The output, direction, blink, polarity, edge-enable and level-enable registers read back the last value written. An access whose two low address bits are not 00 writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value driven onto each pad |
| pad_oe | output | 32 | Pad output enable, high for output lines |
| irq | output | 4 | One interrupt per group of eight lines |

## Verification
A stale or wrongly updated pending bit shows on the group interrupt output on the next clock edge once its enable bit is set. It also reads back wrongly at 0x14 at once, so the bench checks the pending register after each acknowledge write and after each race. A synchronizer with the wrong depth moves the corrected input by one cycle, which the bench catches by reading 0x10 both one and two edges after a pad change. A broken blink prescaler shows on the pad as a wrong duty within one wave period.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int REG_ADDR_W = 5;

    // register selected by bits [4:2] of the byte address
    typedef enum logic [2:0] {
        SEL_OUT   = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_BLINK = 3'd2,
        SEL_POL   = 3'd3,
        SEL_DIN   = 3'd4,
        SEL_CAUSE = 3'd5,
        SEL_EMASK = 3'd6,
        SEL_LMASK = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     hit;   // word-aligned access
        reg_sel_e sel;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [REG_ADDR_W-1:0] a);
        reg_dec_t d;
        d.hit = (a[1:0] == 2'b00);
        d.sel = reg_sel_e'(a[4:2]);
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
    parameter int CNT_W = 20
) (
    input  logic clk,
    input  logic rst,
    output logic wave
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign wave = cnt_q[CNT_W-1];

    AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1) |=> (wave != $past(wave))); // R10
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int NPINS = 32,
    parameter int GROUP = 8,
    localparam int NGROUP = NPINS / GROUP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  din,
    input  logic              clr_wr,
    input  logic [NPINS-1:0]  clr_data,
    input  logic [NPINS-1:0]  edge_en,
    input  logic [NPINS-1:0]  level_en,
    output logic [NPINS-1:0]  cause_q,
    output logic [NGROUP-1:0] irq
);
    logic [NPINS-1:0] din_q;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] keep;
    logic [NPINS-1:0] pend;

    assign rise = din & ~din_q;
    assign keep = clr_wr ? clr_data : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q   <= '0;
            cause_q <= '0;
        end else begin
            din_q   <= din;
            cause_q <= (cause_q & keep) | rise;   // new edge beats the clear
        end
    end

    assign pend = (din & level_en) | (cause_q & edge_en);

    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        assign irq[g] = |pend[g*GROUP +: GROUP];
    end

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((cause_q & $past(rise)) == $past(rise))); // R5
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && |(rise & ~clr_data)) |=> ((cause_q & $past(rise)) == $past(rise))); // R8
    AST_NO_SPURIOUS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ((cause_q & ~$past(cause_q) & ~$past(rise)) == '0)); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((cause_q & ~$past(clr_data) & ~$past(rise)) == '0)); // R7
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NPINS   = 32,
    parameter int GROUP   = 8,
    parameter int BLINK_W = 20,
    localparam int NGROUP = NPINS / GROUP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic [NPINS-1:0]      bus_wdata,
    output logic [NPINS-1:0]      bus_rdata,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_oe,
    output logic [NGROUP-1:0]     irq
);
    reg_dec_t         dec;
    logic             wr;
    logic [NPINS-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
    logic [NPINS-1:0] pad_sync, din, cause;
    logic             wave;

    assign dec = decode_addr(bus_addr);
    assign wr  = bus_we && dec.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (wr) begin
            case (dec.sel)
                SEL_OUT:   out_q   <= bus_wdata;
                SEL_DIR:   dir_q   <= bus_wdata;
                SEL_BLINK: blink_q <= bus_wdata;
                SEL_POL:   pol_q   <= bus_wdata;
                SEL_EMASK: emask_q <= bus_wdata;
                SEL_LMASK: lmask_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(pad_sync)
    );

    assign din = pad_sync ^ pol_q;

    gpio_irq #(.NPINS(NPINS), .GROUP(GROUP)) u_irq (
        .clk(clk), .rst(rst), .din(din),
        .clr_wr(wr && dec.sel == SEL_CAUSE), .clr_data(bus_wdata),
        .edge_en(emask_q), .level_en(lmask_q),
        .cause_q(cause), .irq(irq)
    );

    gpio_blink #(.CNT_W(BLINK_W)) u_blink (
        .clk(clk), .rst(rst), .wave(wave)
    );

    assign pad_oe  = ~dir_q;
    assign pad_out = out_q & (~blink_q | {NPINS{wave}});

    always_comb begin
        bus_rdata = '0;
        if (dec.hit) begin
            case (dec.sel)
                SEL_OUT:   bus_rdata = out_q;
                SEL_DIR:   bus_rdata = dir_q;
                SEL_BLINK: bus_rdata = blink_q;
                SEL_POL:   bus_rdata = pol_q;
                SEL_DIN:   bus_rdata = din;
                SEL_CAUSE: bus_rdata = cause;
                SEL_EMASK: bus_rdata = emask_q;
                SEL_LMASK: bus_rdata = lmask_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> ((irq == '0) && (pad_oe == '0))); // R1
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((emask_q == '0) && (lmask_q == '0)) |-> (irq == '0)); // R6
    AST_PLAIN_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        ((pad_out & ~blink_q) == (out_q & ~blink_q))); // R2
endmodule

// File: tb/tb_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_ctrl;
    localparam int BW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic [3:0]  irq;

    int tests = 0;
    int fails = 0;

    localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_BLINK = 5'h08, A_POL = 5'h0C,
                           A_DIN = 5'h10, A_CAUSE = 5'h14, A_EMASK = 5'h18, A_LMASK = 5'h1C;

    always #2 clk = ~clk;

    gpio_ctrl #(.NPINS(32), .GROUP(8), .BLINK_W(BW)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic setpad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {28'd0, irq}, 32'd0);
        check("R1 pad_oe", pad_oe, 32'd0);
        rd(A_CAUSE, d); check("R1 cause", d, 32'd0);
        rd(A_EMASK, d); check("R1 edge enable", d, 32'd0);
        rd(A_LMASK, d); check("R1 level enable", d, 32'd0);
        rd(A_DIR, d);   check("R1 direction", d, 32'hFFFF_FFFF);
        rd(A_POL, d);   check("R1 polarity", d, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(A_OUT, 32'hDEAD_BEEF);   rd(A_OUT, d);   check("R11 out readback", d, 32'hDEAD_BEEF);
        wr(A_BLINK, 32'h0F0F_0F0F); rd(A_BLINK, d); check("R11 blink readback", d, 32'h0F0F_0F0F);
        wr(A_EMASK, 32'h1234_5678); rd(A_EMASK, d); check("R11 edge en readback", d, 32'h1234_5678);
        wr(A_LMASK, 32'h8765_4321); rd(A_LMASK, d); check("R11 level en readback", d, 32'h8765_4321);
        wr(5'h01, 32'h0);           rd(A_OUT, d);   check("R11 unaligned write ignored", d, 32'hDEAD_BEEF);
        rd(5'h01, d);               check("R11 unaligned read zero", d, 32'd0);
        wr(A_EMASK, 0); wr(A_LMASK, 0); wr(A_BLINK, 0); wr(A_OUT, 0);
    endtask

    task automatic t_datain();
        logic [31:0] d;
        wr(A_POL, 32'h0000_FFFF);
        rd(A_POL, d); check("R11 polarity readback", d, 32'h0000_FFFF);
        setpad(32'hA5A5_0F0F);
        bus_addr = A_DIN;
        edges(1); check("R3 datain not yet after one edge", bus_rdata, 32'h0000_FFFF);
        edges(1); check("R3 datain after two edges", bus_rdata, 32'hA5A5_F0F0);
        wr(A_DIN, 32'h0);
        rd(A_DIN, d); check("R3 write to datain ignored", d, 32'hA5A5_F0F0);
        wr(A_POL, 0);
        setpad(0);
        edges(4);
        wr(A_CAUSE, 0);
    endtask

    task automatic t_output();
        logic [31:0] d;
        wr(A_DIR, 32'hFFFF_0000);
        wr(A_OUT, 32'h1234_5678);
        rd(A_DIR, d); check("R11 direction readback", d, 32'hFFFF_0000);
        check("R2 pad_oe follows direction", pad_oe, 32'h0000_FFFF);
        check("R2 pad_out on outputs", pad_out & pad_oe, 32'h0000_5678);
        wr(A_DIR, 32'hFFFF_FFFF);
        check("R2 all inputs no enable", pad_oe, 32'd0);
        wr(A_OUT, 0);
    endtask

    task automatic t_level();
        wr(A_LMASK, 32'h0000_0200);
        setpad(32'h0000_0200); edges(2);
        check("R4 level high asserts group1", {28'd0, irq}, 32'h2);
        setpad(0); edges(2);
        check("R4 level not latched", {28'd0, irq}, 32'h0);
        wr(A_POL, 32'h0000_0200);
        check("R4 active-low via polarity", {28'd0, irq}, 32'h2);
        wr(A_POL, 0);
        wr(A_LMASK, 0);
        edges(2);
        wr(A_CAUSE, 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        setpad(32'h0010_0000); edges(3);
        bus_addr = A_CAUSE; #0.5;
        check("R5 rising edge latched", bus_rdata, 32'h0010_0000);
        check("R6 disabled edge stays off irq", {28'd0, irq}, 32'h0);
        wr(A_EMASK, 32'h0010_0000);
        check("R6 enabled edge drives irq2", {28'd0, irq}, 32'h4);
        setpad(0); edges(4);
        check("R5 edge held after input falls", {28'd0, irq}, 32'h4);
        wr(A_POL, 32'h0000_0008);
        edges(3);
        wr(A_CAUSE, 0);
        rd(A_CAUSE, d); check("R7 zero write clears all", d, 32'd0);
        setpad(32'h0000_0008); edges(4);
        rd(A_CAUSE, d); check("R5 inverted rise not latched", d, 32'd0);
        setpad(0); edges(3);
        bus_addr = A_CAUSE; #0.5;
        check("R5 falling pad edge latched with polarity", bus_rdata, 32'h0000_0008);
        setpad(32'h0010_0000); edges(4);
        wr(A_CAUSE, 32'hFFFF_FFF7);
        rd(A_CAUSE, d); check("R7 selective clear", d, 32'h0010_0000);
        wr(A_CAUSE, 0);
        rd(A_CAUSE, d); check("R7 clear remaining", d, 32'd0);
        check("R7 irq drops after ack", {28'd0, irq}, 32'h0);
        wr(A_POL, 0); wr(A_EMASK, 0);
        setpad(0); edges(4);
        wr(A_CAUSE, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        setpad(32'h2); edges(4);
        setpad(32'h3);
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_CAUSE; bus_wdata = 0; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1 check("R8 new edge beats clear", bus_rdata, 32'h1);
        setpad(0); edges(4);
        wr(A_CAUSE, 0);
        rd(A_CAUSE, d); check("R8 cleared afterwards", d, 32'd0);
    endtask

    task automatic t_group();
        int pins [8] = '{0, 7, 8, 15, 16, 23, 24, 31};
        wr(A_LMASK, 32'hFFFF_FFFF);
        foreach (pins[i]) begin
            setpad(32'h1 << pins[i]); edges(2);
            check($sformatf("R9 pin %0d group", pins[i]), {28'd0, irq}, 32'h1 << (pins[i] / 8));
        end
        setpad(0); edges(2);
        wr(A_LMASK, 0);
        wr(A_CAUSE, 0);
    endtask

    task automatic t_blink();
        int ones;
        int flips;
        logic prev;
        wr(A_DIR, 32'hFFFF_FFFE);
        wr(A_OUT, 32'h1);
        wr(A_BLINK, 32'h1);
        ones = 0; flips = 0; prev = pad_out[0];
        for (int k = 0; k < (1 << BW); k++) begin
            @(negedge clk);
            if (pad_out[0]) ones++;
            if (pad_out[0] != prev) flips++;
            prev = pad_out[0];
        end
        check("R10 blink half duty", ones, (1 << BW) / 2);
        check("R10 blink toggles", (flips > 0) ? 1 : 0, 1);
        wr(A_OUT, 32'h0);
        ones = 0;
        for (int k = 0; k < (1 << BW); k++) begin
            @(negedge clk);
            if (pad_out[0]) ones++;
        end
        check("R10 blink with output 0 stays low", ones, 0);
        wr(A_OUT, 32'h1);
        wr(A_BLINK, 32'h0);
        ones = 0;
        for (int k = 0; k < (1 << BW); k++) begin
            @(negedge clk);
            if (pad_out[0]) ones++;
        end
        check("R10 no blink steady high", ones, 1 << BW);
        wr(A_OUT, 0); wr(A_DIR, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_datain();
        t_output();
        t_level();
        t_edge();
        t_race();
        t_group();
        t_blink();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule